// File: doc/BRIEF.md
# Time-over-threshold hit digitizer

This block turns the sampled output of a single channel's discriminator into compact hit records. On every tick of the sample clock it looks at the comparator level. When the level rises, it captures the current value of a free-running 5-bit time counter as the hit's leading-edge timestamp and starts counting how many consecutive samples the level stays high. When the level falls, the count is compressed into a 4-bit logarithmic width code. The timestamp and code pair is then committed to a small first-in first-out store.

A downstream reader sees the oldest stored hit on the output pins whenever the valid flag is high, and removes it with a one-cycle pop strobe. The store holds four hits. A hit that arrives while the store is full is dropped and a sticky overflow flag is raised. The reset is asynchronous and active-low, and the block releases it in step with the clock.

Top module: `tot_digitizer`

## Requirements
- R1: After reset, hit_valid_o is 0 and overflow_o is 0.
- R2: A hit's timestamp equals the value on time_i at the first clock edge at which comp_i is sampled high after being low.
- R3: The width W is the number of consecutive clock edges at which comp_i is sampled high. The code is floor(log2(W))+1, clamped to 15 (W=1 gives 1, W=2..3 gives 2, W=16384..32767 gives 15).
- R4: The width counter saturates at 65535 rather than wrapping, so a pulse of 70000 samples yields code 15.
- R5: A hit is committed at the first edge at which comp_i is sampled low after being high. It is not visible while comp_i is still high, and it appears on the outputs right after the committing edge.
- R6: Stored hits leave in arrival order, and up to four are held at once.
- R7: A hit that completes while four are stored and no pop occurs is discarded, and overflow_o goes to 1 and stays at 1 until reset.
- R8: When the store is full, a pop and a commit at the same edge both take effect: the oldest hit leaves and the new one is kept.
- R9: A pop while the store is empty has no effect. Valid stays 0, and later hits come out normally.
- R10: While hit_valid_o is 1, hit_ts_o and hit_code_o show the oldest stored hit, with the timestamp in 5 bits and the code in 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_i | input | 1 | Discriminator level |
| time_i | input | 5 | Free-running time counter value |
| pop_i | input | 1 | Remove the oldest stored hit |
| hit_valid_o | output | 1 | At least one hit is stored |
| hit_ts_o | output | 5 | Leading-edge timestamp of the oldest hit |
| hit_code_o | output | 4 | Logarithmic width code of the oldest hit |
| overflow_o | output | 1 | Sticky flag: a hit was dropped |

## Verification
Several properties are checked on every cycle. The width counter holds at its ceiling once saturated. The timestamp holds steady through a pulse. The store occupancy never exceeds four. A dropped hit leaves the occupancy unchanged, and the overflow flag never clears by itself. A simultaneous pop and commit on a full store leaves it full, and a pop on an empty store leaves it empty. Only the bench scenarios can show that the code values are correct across all widths from 1 to 40 and at the large-width boundaries, that timestamps match the counter at the rising edge, and that hits come out in order.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int TS_W     = 5;
  localparam int CODE_W   = 4;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [CODE_W-1:0] code;
  } hit_t;
endpackage

// File: rtl/tot_width_meter.sv
module tot_width_meter
  import tot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_i,
  input  logic [TS_W-1:0]  time_i,
  output logic [TS_W-1:0]  ts_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             level_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic             rise, hold, cnt_en;

  assign rise = comp_i & ~level_q;
  assign hold = comp_i & level_q;

  always_comb begin
    cnt_d  = cnt_q;
    ts_d   = ts_q;
    cnt_en = 1'b0;
    if (rise) begin
      cnt_d  = CNT_W'(1);
      ts_d   = time_i;
      cnt_en = 1'b1;
    end else if (hold && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
      ts_q    <= '0;
    end else begin
      level_q <= comp_i;
      if (cnt_en) cnt_q <= cnt_d;
      if (rise)   ts_q  <= ts_d;
    end
  end

  assign ts_o   = ts_q;
  assign cnt_o  = cnt_q;
  assign done_o = ~comp_i & level_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q && comp_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R4
  AST_TS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q && comp_i) |=> $stable(ts_q)); // R2
endmodule

// File: rtl/tot_log_encoder.sv
module tot_log_encoder
  import tot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] code_o
);
  int msb_pos;

  always_comb begin
    msb_pos = 0;
    for (int i = 0; i < CNT_W; i++) begin
      if (cnt_i[i]) msb_pos = i + 1;
    end
    if (msb_pos > CODE_MAX) code_o = CODE_W'(CODE_MAX);
    else                    code_o = CODE_W'(msb_pos);
  end
endmodule

// File: rtl/tot_hit_fifo.sv
module tot_hit_fifo
  import tot_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  hit_t data_i,
  input  logic pop_i,
  output logic valid_o,
  output hit_t data_o,
  output logic ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = PTR_W + 1;
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

  hit_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             ovf_q, ovf_d;
  logic             full, empty, do_pop, do_push;

  assign full    = (occ_q == OCC_FULL);
  assign empty   = (occ_q == '0);
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & (~full | do_pop);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = do_push ? ptr_next(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_next(rd_q) : rd_q;
    occ_d = occ_q + OCC_W'(do_push) - OCC_W'(do_pop);
    ovf_d = ovf_q | (push_i & ~do_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == PTR_W'(g))) mem_q[g] <= data_i;
    end
  end

  assign valid_o = ~empty;
  assign data_o  = mem_q[rd_q];
  assign ovf_o   = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_FULL); // R6
  AST_DROP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> $stable(occ_q)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R7
  AST_SWAP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full) |=> (occ_q == OCC_FULL)); // R8
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !push_i) |=> (occ_q == '0)); // R9
endmodule

// File: rtl/tot_digitizer.sv
module tot_digitizer
  import tot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_i,
  input  logic [TS_W-1:0]   time_i,
  input  logic              pop_i,
  output logic              hit_valid_o,
  output logic [TS_W-1:0]   hit_ts_o,
  output logic [CODE_W-1:0] hit_code_o,
  output logic              overflow_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [TS_W-1:0]  lead_ts;
  logic [CNT_W-1:0] width_cnt;
  logic             hit_done;
  logic [CODE_W-1:0] width_code;
  hit_t             new_hit, head_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tot_width_meter #(.CNT_W(CNT_W)) meter_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .comp_i (comp_i),
    .time_i (time_i),
    .ts_o   (lead_ts),
    .cnt_o  (width_cnt),
    .done_o (hit_done)
  );

  tot_log_encoder #(.CNT_W(CNT_W)) enc_i (
    .cnt_i  (width_cnt),
    .code_o (width_code)
  );

  assign new_hit.ts   = lead_ts;
  assign new_hit.code = width_code;

  tot_hit_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (hit_done),
    .data_i  (new_hit),
    .pop_i   (pop_i),
    .valid_o (hit_valid_o),
    .data_o  (head_hit),
    .ovf_o   (overflow_o)
  );

  assign hit_ts_o   = head_hit.ts;
  assign hit_code_o = head_hit.code;

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit_done |-> (width_code != '0)); // R3
endmodule

// File: tb/tot_digitizer_tb.sv
module tot_digitizer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       comp;
  logic [4:0] tcnt;
  logic       pop;
  logic       valid;
  logic [4:0] ts;
  logic [3:0] code;
  logic       ovf;

  int n_tests = 0;
  int n_fail  = 0;
  logic [8:0] model_q [$];
  bit exp_ovf = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= 5'd0;
    else        tcnt <= tcnt + 5'd1;
  end

  tot_digitizer dut_i (
    .clk(clk), .rst_n(rst_n), .comp_i(comp), .time_i(tcnt), .pop_i(pop),
    .hit_valid_o(valid), .hit_ts_o(ts), .hit_code_o(code), .overflow_o(ovf)
  );

  function automatic logic [3:0] exp_code(input int w);
    int c = 0;
    int s = (w > 65535) ? 65535 : w;
    for (int b = 0; b < 17; b++) if (((s >> b) & 1) == 1) c = b + 1;
    return (c > 15) ? 4'd15 : 4'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_push(input logic [8:0] h);
    if (model_q.size() < 4) model_q.push_back(h);
    else exp_ovf = 1'b1;
  endtask

  // check head against model, then pop it
  task automatic pop_check(input string req);
    logic [8:0] e;
    e = model_q[0];
    chk(valid === 1'b1, req, int'(valid), 1);
    chk({ts, code} === e, req, int'({ts, code}), int'(e));
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    void'(model_q.pop_front());
  endtask

  // pulse of w samples; optional pop at the committing edge
  task automatic pulse(input int w, input bit pop_at_fall, input bit chk_commit);
    logic [4:0] lead;
    logic [8:0] h;
    bit was_empty;
    was_empty = (model_q.size() == 0);
    comp = 1'b1;
    lead = tcnt;
    repeat (w) @(negedge clk);
    if (chk_commit && was_empty) chk(valid === 1'b0, "R5 not yet committed", int'(valid), 0);
    comp = 1'b0;
    h = {lead, exp_code(w)};
    if (pop_at_fall) begin
      chk({ts, code} === model_q[0], "R8 head before swap", int'({ts, code}), int'(model_q[0]));
      pop = 1'b1;
      void'(model_q.pop_front());
    end
    @(negedge clk);
    pop = 1'b0;
    model_push(h);
    if (chk_commit && was_empty) chk(valid === 1'b1, "R5 committed after fall", int'(valid), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    comp = 1'b0;
    pop = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid === 1'b0, "R1 valid after reset", int'(valid), 0);
    chk(ovf === 1'b0, "R1 overflow after reset", int'(ovf), 0);

    // R2 R3 R5 R10: sweep of widths 1..40
    for (int w = 1; w <= 40; w++) begin
      pulse(w, 1'b0, 1'b1);
      pop_check("R3 R2 R10 sweep");
      chk(valid === 1'b0, "R10 empty after pop", int'(valid), 0);
    end

    // R6 R7: five hits without popping
    for (int k = 0; k < 5; k++) pulse(k + 2, 1'b0, 1'b0);
    chk(ovf === 1'b1, "R7 overflow set", int'(ovf), 1);
    for (int k = 0; k < 4; k++) pop_check("R6 order");
    chk(valid === 1'b0, "R6 drained", int'(valid), 0);

    // R9: pop while empty
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
    chk(valid === 1'b0, "R9 empty pop ignored", int'(valid), 0);
    pulse(9, 1'b0, 1'b1);
    pop_check("R9 normal after empty pop");

    // R8: full store, pop and commit at the same edge
    for (int k = 0; k < 4; k++) pulse(k + 1, 1'b0, 1'b0);
    pulse(12, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) pop_check("R8 swap kept");
    chk(valid === 1'b0, "R8 drained", int'(valid), 0);
    chk(ovf === 1'b1, "R7 overflow sticky", int'(ovf), 1);

    // R3 R4: large widths
    pulse(16383, 1'b0, 1'b0);
    pop_check("R3 width 16383");
    pulse(16384, 1'b0, 1'b0);
    pop_check("R3 width 16384 clamp");
    pulse(70000, 1'b0, 1'b0);
    pop_check("R4 saturation");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule